// File: doc/BRIEF.md
# Counter, LFSR and PWM Pattern Generator

This block is a small free-running pattern source. It holds two state registers: an 8-bit up-counter that advances on every clock and wraps, and an 8-bit maximal-length Fibonacci shift register that steps on every clock. A single PWM bit is formed by comparing the counter with a duty threshold input. A 2-bit mode select routes one of four views onto an 8-bit output bus:

- the counter;
- the shift register;
- the PWM bit copied across all eight lanes;
- the bitwise XOR of counter and shift register.

The output bus and the PWM bit are purely combinational functions of the two registers and the inputs. Changing the mode or the threshold therefore takes effect in the same cycle and never disturbs the state. Only the two 8-bit registers hold state, so the block has 16 flip-flops. The logic is shallow enough to close timing at 100 MHz.

Top module: `pattern_gen`

## Requirements
- R1: While `rst_n` is low, the counter is held at 0 and the shift register at the seed 8'h01. Both values can be seen on `pat_out` in mode 2'b00 and mode 2'b01.
- R2: The counter increments by one on every rising clock edge after reset is released, wrapping from 255 to 0. Over the first 1024 cycles after release it wraps exactly four times.
- R3: The shift register steps as next = {q[6:0], q[7]^q[5]^q[4]^q[3]}. Bit 0 receives the feedback and the register shifts toward bit 7 (taps 8, 6, 5, 4 counted from 1).
- R4: Starting from the seed, the shift register visits all 255 non-zero values exactly once before it returns to 8'h01. It is never zero.
- R5: `pwm_out` is high exactly when the counter value is less than `duty_thr`. With `duty_thr` = 64 it is high on 256 of any 1024 consecutive cycles.
- R6: With `duty_thr` = 0, `pwm_out` is constantly low. With `duty_thr` = 255 it is high on 1020 of 1024 cycles and is never high on every cycle.
- R7: `mode_sel` 2'b00 drives the counter onto `pat_out`; 2'b01 drives the shift register.
- R8: `mode_sel` 2'b10 drives `pwm_out` onto all eight bits of `pat_out`; 2'b11 drives counter XOR shift register.
- R9: A change of `mode_sel` changes `pat_out` in the same cycle and does not alter the counter or shift register sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| mode_sel | input | 2 | Selects the source of `pat_out` |
| duty_thr | input | 8 | PWM compare threshold |
| pat_out | output | 8 | Selected pattern |
| pwm_out | output | 1 | PWM bit, high while counter < threshold |

## Verification
A counter that skips or sticks shows up in mode 00 on the very next cycle. It also shifts the PWM edges, so a 1024-cycle high count drifts from its expected total. A wrong tap or a lost feedback bit first appears as a value mismatch one cycle after it is hit. It also shortens the period: a value repeats, or zero appears, well before 255 steps. Mux faults are combinational and are visible in the same cycle the mode is applied.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int unsigned PG_WIDTH = 8;
  localparam logic [PG_WIDTH-1:0] PG_TAPS = 8'hB8;  // bits 7,5,4,3
  localparam logic [PG_WIDTH-1:0] PG_SEED = 8'h01;

  typedef enum logic [1:0] {
    SEL_COUNT = 2'b00,
    SEL_SHIFT = 2'b01,
    SEL_PWM   = 2'b10,
    SEL_MIX   = 2'b11
  } pg_sel_e;
endpackage

// File: rtl/pg_counter.sv
module pg_counter #(
  parameter int unsigned W = pg_pkg::PG_WIDTH
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt_q
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pg_lfsr.sv
module pg_lfsr #(
  parameter int unsigned   W    = pg_pkg::PG_WIDTH,
  parameter logic [W-1:0]  TAPS = pg_pkg::PG_TAPS,
  parameter logic [W-1:0]  SEED = pg_pkg::PG_SEED
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] lfsr_q
);
  logic [W-1:0] tapped;
  logic         fb;
  logic [W-1:0] lfsr_d;

  // mask out non-tap bits, then reduce
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_tap
      assign tapped[i] = TAPS[i] & lfsr_q[i];
    end
  endgenerate

  always_comb begin
    fb     = ^tapped;
    lfsr_d = {lfsr_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_d;
  end
endmodule

// File: rtl/pg_outmux.sv
module pg_outmux #(
  parameter int unsigned W = pg_pkg::PG_WIDTH
) (
  input  logic [1:0]   mode_sel,
  input  logic [W-1:0] duty_thr,
  input  logic [W-1:0] cnt_q,
  input  logic [W-1:0] lfsr_q,
  output logic [W-1:0] pat_out,
  output logic         pwm_out
);
  import pg_pkg::*;

  pg_sel_e sel;

  always_comb begin
    pwm_out = (cnt_q < duty_thr);
    sel     = pg_sel_e'(mode_sel);
    unique case (sel)
      SEL_COUNT: pat_out = cnt_q;
      SEL_SHIFT: pat_out = lfsr_q;
      SEL_PWM:   pat_out = {W{pwm_out}};
      SEL_MIX:   pat_out = cnt_q ^ lfsr_q;
      default:   pat_out = '0;
    endcase
  end
endmodule

// File: rtl/pattern_gen.sv
module pattern_gen #(
  parameter int unsigned W = pg_pkg::PG_WIDTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_sel,
  input  logic [W-1:0] duty_thr,
  output logic [W-1:0] pat_out,
  output logic         pwm_out
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lfsr_q;

  pg_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_q (cnt_q)
  );

  pg_lfsr #(.W(W)) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .lfsr_q (lfsr_q)
  );

  pg_outmux #(.W(W)) u_mux (
    .mode_sel (mode_sel),
    .duty_thr (duty_thr),
    .cnt_q    (cnt_q),
    .lfsr_q   (lfsr_q),
    .pat_out  (pat_out),
    .pwm_out  (pwm_out)
  );
endmodule

// File: rtl/pattern_gen_chk.sv
module pattern_gen_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode_sel,
  input logic [W-1:0] duty_thr,
  input logic [W-1:0] pat_out,
  input logic         pwm_out,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] lfsr_q
);
  localparam logic [W-1:0] ONE = W'(1);

  p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cnt_q == '0 && lfsr_q == ONE));

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(rst_n) |-> (cnt_q == $past(cnt_q) + ONE));

  p_lfsr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(rst_n) |-> (lfsr_q == {$past(lfsr_q[W-2:0]),
      $past(lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3])}));

  p_lfsr_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  p_pwm_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_thr == '0) |-> !pwm_out);

  p_pwm_wrap_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1) |-> !pwm_out);

  p_mode_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |-> (pat_out == cnt_q));

  p_mode_pwm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10) |-> ($countones(pat_out) == (pwm_out ? W : 0)));
endmodule

bind pattern_gen pattern_gen_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_sel (mode_sel),
  .duty_thr (duty_thr),
  .pat_out  (pat_out),
  .pwm_out  (pwm_out),
  .cnt_q    (cnt_q),
  .lfsr_q   (lfsr_q)
);

// File: tb/pattern_gen_tb.sv
module pattern_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [7:0] duty_thr = 8'd64;
  logic [7:0] pat_out;
  logic       pwm_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] ref_cnt = 8'd0;
  logic [7:0] ref_lfsr = 8'h01;

  always #10 clk = ~clk;

  pattern_gen u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .duty_thr(duty_thr), .pat_out(pat_out), .pwm_out(pwm_out)
  );

  function automatic logic [7:0] lfsr_step(input logic [7:0] v);
    return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) begin
      ref_cnt  = ref_cnt + 8'd1;
      ref_lfsr = lfsr_step(ref_lfsr);
    end
    @(negedge clk);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ref_cnt = 8'd0;
    ref_lfsr = 8'h01;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    apply_reset();
    rst_n = 1'b0;
    step(); step();
    mode_sel = 2'b00; #1;
    chk(pat_out == 8'd0, "R1 counter reset", pat_out, 0);
    mode_sel = 2'b01; #1;
    chk(pat_out == 8'h01, "R1 shift seed", pat_out, 1);
    rst_n = 1'b1;
  endtask

  task automatic t_counter_wrap();
    int wraps = 0;
    int bad = 0;
    logic [7:0] prev;
    apply_reset();
    mode_sel = 2'b00;
    #1 prev = pat_out;
    for (int i = 0; i < 1024; i++) begin
      step();
      if (pat_out != ref_cnt) bad++;
      if (prev == 8'd255 && pat_out == 8'd0) wraps++;
      prev = pat_out;
    end
    chk(bad == 0, "R2 counter sequence", bad, 0);
    chk(wraps == 4, "R2 wrap count", wraps, 4);
  endtask

  task automatic t_lfsr_cover();
    bit seen [256];
    int bad_val = 0;
    int dup = 0;
    int zero = 0;
    apply_reset();
    mode_sel = 2'b01;
    for (int i = 0; i < 256; i++) seen[i] = 1'b0;
    seen[1] = 1'b1;
    for (int i = 0; i < 254; i++) begin
      step();
      if (pat_out != ref_lfsr) bad_val++;
      if (pat_out == 8'd0) zero++;
      if (seen[pat_out]) dup++;
      seen[pat_out] = 1'b1;
    end
    chk(bad_val == 0, "R3 shift sequence", bad_val, 0);
    chk(zero == 0, "R4 zero state", zero, 0);
    chk(dup == 0, "R4 repeated state", dup, 0);
    step();
    chk(pat_out == 8'h01, "R4 period 255", pat_out, 1);
  endtask

  task automatic t_pwm(input logic [7:0] thr, input int exp_hi, input string req);
    int hi = 0;
    int bad = 0;
    int lane = 0;
    apply_reset();
    mode_sel = 2'b10;
    duty_thr = thr;
    for (int i = 0; i < 1024; i++) begin
      step();
      if (pwm_out) hi++;
      if (pwm_out != (ref_cnt < thr)) bad++;
      if (pat_out != {8{pwm_out}}) lane++;
    end
    chk(hi == exp_hi, req, hi, exp_hi);
    chk(bad == 0, "R5 compare", bad, 0);
    chk(lane == 0, "R8 pwm lanes", lane, 0);
    duty_thr = 8'd64;
  endtask

  task automatic t_modes();
    int bad = 0;
    apply_reset();
    duty_thr = 8'd100;
    for (int i = 0; i < 40; i++) begin
      step();
      mode_sel = 2'(i % 4);
      #1;
      case (mode_sel)
        2'b00: if (pat_out != ref_cnt) bad++;
        2'b01: if (pat_out != ref_lfsr) bad++;
        2'b10: if (pat_out != {8{ref_cnt < 8'd100}}) bad++;
        default: if (pat_out != (ref_cnt ^ ref_lfsr)) bad++;
      endcase
    end
    chk(bad == 0, "R7 R8 mode views", bad, 0);
    mode_sel = 2'b11; #1;
    chk(pat_out == (ref_cnt ^ ref_lfsr), "R8 mix view", pat_out, ref_cnt ^ ref_lfsr);
    step();
    mode_sel = 2'b00; #1;
    chk(pat_out == ref_cnt, "R9 counter undisturbed", pat_out, ref_cnt);
    mode_sel = 2'b01; #1;
    chk(pat_out == ref_lfsr, "R9 shift undisturbed", pat_out, ref_lfsr);
    duty_thr = 8'd64;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_counter_wrap();
    t_lfsr_cover();
    t_pwm(8'd64, 256, "R5 duty 64");
    t_pwm(8'd0, 0, "R6 duty 0");
    t_pwm(8'd255, 1020, "R6 duty 255");
    t_modes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule